// File: doc/BRIEF.md
# Multi-Domain Reset Sequencer

This block gathers nine reset request lines and drives four active-high reset outputs. The outputs are the processor core reset, the peripheral reset, the reset for the pin-configuration part of the debug port, and the reset for the whole debug/JTAG logic. Each request is first brought into the clock domain by a two-flop synchroniser. It is then sorted into one of three classes:

- **full**: all four outputs.
- **system**: core, peripheral and debug pin-configuration, leaving the debug logic running.
- **core-only**: the core alone.

Four of the sources (external pin, brownout, hibernation wake, watchdog) take their class from a software behaviour register. Simultaneous requests assert the union of their output sets. The outputs stay asserted for a minimum hold time after the last request leaves, and they are released together on a clock edge.

A sticky cause register keeps one bit per source, and software clears its bits by writing ones. A full-class reset wipes the cause and behaviour registers as it begins. Only the sources active at that moment remain recorded in the cause register. The block's own supply-good input `rst_ni` clears everything and starts a full reset with the minimum hold.

The sequencer is a three-state machine:

- **IDLE**: no reset. A synchronised request moves it to ASSERT.
- **ASSERT**: requests are present, and their output sets are merged into the held set. When the last one leaves, the machine moves to STRETCH and loads the hold counter.
- **STRETCH**: the counter counts down. A new request returns the machine to ASSERT. When the counter is spent, the machine returns to IDLE and releases all outputs.

Top module: `rst_domain_ctrl`

## Requirements
- R1: A request held steady asserts its outputs at the third rising edge after it is applied: two synchroniser stages, then the held set register.
- R2: Request bit 0 (power-on) always produces the full class: outputs core, peripheral, debug-pin and debug all high.
- R3: Software system reset (bit 3), service restart (bit 6) and oscillator failure (bit 7) always produce the system class: core, peripheral and debug-pin high, debug low. The pin (bit 1) and the watchdog (bit 4) also produce the system class by default.
- R4: Request bit 8 (software core-only reset) asserts the core output only.
- R5: The behaviour register holds four 2-bit fields:
  - pin at [1:0], brownout at [3:2], hibernation (bit 5) at [5:4], and watchdog at [7:6].
  - Code 10 selects the system class and 11 selects the full class.
  - Codes 00 and 01 select the default class. The default is full for the brownout (bit 2) and for hibernation, and system for the pin and for the watchdog.
- R6: Once the last synchronised request goes low, every asserted output stays high for at least MIN_HOLD (16) cycles. All outputs then fall on the same edge.
- R7: Requests active together assert the union of their output sets, so a full-class request dominates any other.
- R8: The cause register, at address 0x0, sets bit n whenever synchronised request n is high. The bit stays set across system and core-only resets. Writing 1 to bit n clears it, and a request that is still active overrides the clear.
- R9: When a full-class reset begins, the behaviour register is cleared to 0. The cause register is cleared too, except for the bits of the requests active at that moment.
- R10: The behaviour register reads and writes at address 0x4 (bits [7:0]). Every other address reads 0, and both registers read 0 after `rst_ni`.
- R11: While `rst_ni` is low all four outputs are high. They are released MIN_HOLD cycles after `rst_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Supply-good reset of the block itself, active low, asynchronous |
| req_i | input | 9 | Asynchronous reset requests, one per source (bit order as in the requirements) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| rst_core_o | output | 1 | Processor core reset |
| rst_periph_o | output | 1 | Peripheral reset |
| rst_dbgpin_o | output | 1 | Debug pin-configuration reset |
| rst_dbg_o | output | 1 | Full debug/JTAG logic reset |

## Verification
Every source is pulsed alone with the default behaviour codes, which tells the three classes apart through the state of the debug and peripheral outputs. The configurable sources are then pulsed again under codes 01, 10 and 11. This separates a correct field decode from a swapped field or a code that is ignored. Paired requests (a system-class request with the core-only reset, and power-on with the core-only reset) show whether the union and the full-class dominance hold. Every pulse is also timed from its release to the outputs falling, and the cause and behaviour registers are read back to show stickiness, write-one-clear and the wipe on a full-class reset.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    localparam int NSRC = 9;
    localparam int NDOM = 4;

    // request bit positions
    localparam int SRC_POR  = 0;
    localparam int SRC_PIN  = 1;
    localparam int SRC_BOR  = 2;
    localparam int SRC_SWS  = 3;
    localparam int SRC_WDT  = 4;
    localparam int SRC_HIB  = 5;
    localparam int SRC_SVC  = 6;
    localparam int SRC_OSC  = 7;
    localparam int SRC_CORE = 8;

    // output domain bit positions
    localparam int DOM_CORE   = 0;
    localparam int DOM_PERIPH = 1;
    localparam int DOM_DBGPIN = 2;
    localparam int DOM_DBG    = 3;

    typedef logic [NDOM-1:0] dom_t;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_CORE,
        CLS_SYS,
        CLS_FULL
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_STRETCH
    } st_e;

    function automatic dom_t cls_doms(cls_e c);
        dom_t d;
        case (c)
            CLS_FULL: d = 4'b1111;
            CLS_SYS:  d = 4'b0111;
            CLS_CORE: d = 4'b0001;
            default:  d = 4'b0000;
        endcase
        return d;
    endfunction

    function automatic cls_e decode_code(logic [1:0] code, cls_e dflt);
        cls_e c;
        case (code)
            2'b10:   c = CLS_SYS;
            2'b11:   c = CLS_FULL;
            default: c = dflt;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rdc_sync.sv
module rdc_sync #(
    parameter int W = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/rdc_map.sv
module rdc_map
    import rdc_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    input  logic [7:0]      beh_i,
    output dom_t            dom_o
);
    cls_e cls [NSRC];

    always_comb begin
        cls[SRC_POR]  = CLS_FULL;
        cls[SRC_PIN]  = decode_code(beh_i[1:0], CLS_SYS);
        cls[SRC_BOR]  = decode_code(beh_i[3:2], CLS_FULL);
        cls[SRC_SWS]  = CLS_SYS;
        cls[SRC_WDT]  = decode_code(beh_i[7:6], CLS_SYS);
        cls[SRC_HIB]  = decode_code(beh_i[5:4], CLS_FULL);
        cls[SRC_SVC]  = CLS_SYS;
        cls[SRC_OSC]  = CLS_SYS;
        cls[SRC_CORE] = CLS_CORE;
    end

    always_comb begin
        dom_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i]) dom_o = dom_o | cls_doms(cls[i]);
        end
    end
endmodule

// File: rtl/rdc_regs.sv
module rdc_regs
    import rdc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NSRC-1:0]   req_sync_i,
    input  logic              por_begin_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NSRC-1:0]   cause_o,
    output logic [7:0]        beh_o
);
    localparam logic [ADDR_W-1:0] ADDR_CAUSE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_BEH   = ADDR_W'(4);

    logic [NSRC-1:0] cause_q;
    logic [7:0]      beh_q;
    logic [NSRC-1:0] clr_mask;
    logic            unused_wbits;

    assign unused_wbits = ^wdata_i[DATA_W-1:NSRC];
    assign clr_mask = (wr_en_i && addr_i == ADDR_CAUSE) ? wdata_i[NSRC-1:0] : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cause_q <= '0;
            beh_q   <= '0;
        end else if (por_begin_i) begin
            cause_q <= req_sync_i;
            beh_q   <= '0;
        end else begin
            cause_q <= (cause_q & ~clr_mask) | req_sync_i;
            if (wr_en_i && addr_i == ADDR_BEH) beh_q <= wdata_i[7:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CAUSE)    rdata_o[NSRC-1:0] = cause_q;
        else if (addr_i == ADDR_BEH) rdata_o[7:0]      = beh_q;
    end

    assign cause_o = cause_q;
    assign beh_o   = beh_q;
endmodule

// File: rtl/rdc_fsm.sv
module rdc_fsm
    import rdc_pkg::*;
#(
    parameter int MIN_HOLD = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic any_req_i,
    input  dom_t dom_now_i,
    output dom_t held_o,
    output logic por_begin_o
);
    localparam int CW = $clog2(MIN_HOLD + 1);
    localparam logic [CW-1:0] LOAD = CW'(MIN_HOLD - 1);

    st_e         state_q, state_d;
    logic [CW-1:0] cnt_q;
    dom_t        held_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (any_req_i) state_d = ST_ASSERT;
            ST_ASSERT:  if (!any_req_i) state_d = ST_STRETCH;
            ST_STRETCH: begin
                if (any_req_i)       state_d = ST_ASSERT;
                else if (cnt_q == 0) state_d = ST_IDLE;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_STRETCH;
        else         state_q <= state_d;
    end

    // held domain set and hold counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            held_q <= '1;
            cnt_q  <= LOAD;
        end else begin
            unique case (state_d)
                ST_IDLE:    held_q <= '0;
                ST_ASSERT:  held_q <= held_q | dom_now_i;
                default:    held_q <= held_q;
            endcase
            if (state_d == ST_STRETCH && state_q != ST_STRETCH) cnt_q <= LOAD;
            else if (state_q == ST_STRETCH && cnt_q != 0)       cnt_q <= cnt_q - 1'b1;
        end
    end

    assign held_o      = held_q;
    assign por_begin_o = dom_now_i[DOM_DBG] && !held_q[DOM_DBG];
endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
    import rdc_pkg::*;
#(
    parameter int MIN_HOLD = 16,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [8:0]        req_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rst_core_o,
    output logic              rst_periph_o,
    output logic              rst_dbgpin_o,
    output logic              rst_dbg_o
);
    logic [NSRC-1:0] req_sync;
    logic [NSRC-1:0] cause_q;
    logic [7:0]      beh;
    dom_t            dom_now;
    dom_t            held;
    logic            por_begin;

    rdc_sync #(.W(NSRC)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (req_i),
        .q_o   (req_sync)
    );

    rdc_map u_map (
        .req_i(req_sync),
        .beh_i(beh),
        .dom_o(dom_now)
    );

    rdc_fsm #(.MIN_HOLD(MIN_HOLD)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .any_req_i  (|req_sync),
        .dom_now_i  (dom_now),
        .held_o     (held),
        .por_begin_o(por_begin)
    );

    rdc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .req_sync_i (req_sync),
        .por_begin_i(por_begin),
        .rdata_o    (rdata_o),
        .cause_o    (cause_q),
        .beh_o      (beh)
    );

    assign rst_core_o   = held[DOM_CORE];
    assign rst_periph_o = held[DOM_PERIPH];
    assign rst_dbgpin_o = held[DOM_DBGPIN];
    assign rst_dbg_o    = held[DOM_DBG];
endmodule

// File: rtl/rst_domain_ctrl_chk.sv
module rst_domain_ctrl_chk #(
    parameter int MIN_HOLD = 16,
    parameter int ADDR_W   = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [8:0]        req_sync,
    input logic [8:0]        cause_q,
    input logic              por_begin,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rst_core_o,
    input logic              rst_periph_o,
    input logic              rst_dbgpin_o,
    input logic              rst_dbg_o
);
    localparam int QW = $clog2(MIN_HOLD + 1);
    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      quiet_q <= '0;
        else if (|req_sync)               quiet_q <= '0;
        else if (quiet_q != QW'(MIN_HOLD)) quiet_q <= quiet_q + 1'b1;
    end

    a_r2_debug_implies_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_dbg_o |-> (rst_core_o && rst_periph_o && rst_dbgpin_o));

    a_r3_periph_with_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_periph_o == rst_dbgpin_o);

    a_r4_periph_needs_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_periph_o |-> rst_core_o);

    a_r6_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_core_o) |-> (quiet_q >= QW'(MIN_HOLD)));

    a_r6_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rst_core_o) |-> (!rst_periph_o && !rst_dbgpin_o && !rst_dbg_o));

    a_r8_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(wr_en_i && addr_i == ADDR_W'(0)) && !por_begin)
        |=> (($past(cause_q) & ~cause_q) == 9'd0));
endmodule

bind rst_domain_ctrl rst_domain_ctrl_chk #(.MIN_HOLD(MIN_HOLD), .ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_sync    (req_sync),
    .cause_q     (cause_q),
    .por_begin   (por_begin),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .rst_core_o  (rst_core_o),
    .rst_periph_o(rst_periph_o),
    .rst_dbgpin_o(rst_dbgpin_o),
    .rst_dbg_o   (rst_dbg_o)
);

// File: tb/sim_rst_domain_ctrl.sv
`timescale 1ns/1ps
module sim_rst_domain_ctrl;
    localparam int HOLD = 16;
    localparam logic [3:0] D_FULL = 4'b1111;
    localparam logic [3:0] D_SYS  = 4'b0111;
    localparam logic [3:0] D_CORE = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [8:0]  req = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        r_core, r_periph, r_dbgpin, r_dbg;
    logic [3:0]  outs;

    int vectors = 0;
    int misses = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    logic [3:0] q_dom [$];
    int         q_drop [$];
    string      q_tag [$];
    logic [3:0] seen = '0;
    logic [3:0] prev = '0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rst_domain_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .rst_core_o(r_core), .rst_periph_o(r_periph),
        .rst_dbgpin_o(r_dbgpin), .rst_dbg_o(r_dbg)
    );
    assign outs = {r_dbg, r_dbgpin, r_periph, r_core};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: on each release, pop the expected item and compare
    always @(negedge clk) begin
        if (mon_en) begin
            if (outs != 0) seen = seen | outs;
            if (prev != 0 && outs == 0) begin
                if (q_dom.size() == 0) begin
                    check("R6 unexpected release", 32'(seen), 32'h0);
                end else begin
                    logic [3:0] ed;
                    int dr;
                    string tg;
                    int gap;
                    ed = q_dom.pop_front();
                    dr = q_drop.pop_front();
                    tg = q_tag.pop_front();
                    check(tg, 32'(seen), 32'(ed));
                    gap = cyc - dr;
                    check({tg, " R6 hold window"}, 32'((gap >= HOLD + 1) && (gap <= HOLD + 3)), 32'h1);
                end
                seen = '0;
            end
            prev = outs;
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    // driver: apply a request pattern, push expected domains on release
    task automatic fire(input logic [8:0] m, input logic [3:0] exp, input string tag);
        int lat = 0;
        @(negedge clk);
        req = m;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (outs == 0) lat++;
        end
        check({tag, " R1 latency"}, 32'(lat + 1), 32'd3);
        req = '0;
        q_dom.push_back(exp);
        q_drop.push_back(cyc);
        q_tag.push_back(tag);
        for (int i = 0; i < 60; i++) begin
            if (q_dom.size() == 0) break;
            @(negedge clk);
        end
        if (q_dom.size() != 0) begin
            check({tag, " R6 no release"}, 32'(q_dom.size()), 32'd0);
            q_dom.delete(); q_drop.delete(); q_tag.delete();
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R11 outputs in reset", 32'(outs), 32'(D_FULL));
        rst_ni = 1'b1;
        n = 0;
        while (outs != 0 && n < 40) begin
            @(negedge clk);
            n++;
        end
        check("R11 release after hold", 32'((n >= HOLD) && (n <= HOLD + 2)), 32'h1);
        reg_read(4'h0, 32'h0, "R10 cause after reset");
        reg_read(4'h4, 32'h0, "R10 behaviour after reset");
        prev = outs;
        mon_en = 1'b1;

        // default classes, one source at a time
        fire(9'h001, D_FULL, "R2 power-on");     reg_read(4'h0, 32'h001, "R9 cause after power-on");
        fire(9'h002, D_SYS,  "R3 pin default");  reg_read(4'h0, 32'h003, "R8 cause pin");
        fire(9'h004, D_FULL, "R5 brownout default"); reg_read(4'h0, 32'h004, "R9 cause brownout");
        fire(9'h008, D_SYS,  "R3 sw system");    reg_read(4'h0, 32'h00C, "R8 cause sw system");
        fire(9'h010, D_SYS,  "R3 watchdog default"); reg_read(4'h0, 32'h01C, "R8 cause watchdog");
        fire(9'h020, D_FULL, "R5 hibernate default"); reg_read(4'h0, 32'h020, "R9 cause hibernate");
        fire(9'h040, D_SYS,  "R3 service restart");
        fire(9'h080, D_SYS,  "R3 osc failure");
        fire(9'h100, D_CORE, "R4 core only");    reg_read(4'h0, 32'h1E0, "R8 cause sticky across system");

        // write-one-clear
        reg_write(4'h0, 32'h0000_00A0);
        reg_read(4'h0, 32'h140, "R8 write one clear");

        // programmed classes
        reg_write(4'h4, 32'h0000_00EA);
        reg_read(4'h4, 32'h0EA, "R10 behaviour readback");
        fire(9'h004, D_SYS, "R5 brownout code 10");
        fire(9'h002, D_SYS, "R5 pin code 10");
        fire(9'h020, D_SYS, "R5 hibernate code 10");
        reg_read(4'h0, 32'h166, "R8 cause accumulates");
        reg_read(4'h4, 32'h0EA, "R10 behaviour kept over system");
        fire(9'h010, D_FULL, "R5 watchdog code 11");
        reg_read(4'h4, 32'h0, "R9 behaviour wiped");
        reg_read(4'h0, 32'h010, "R9 cause wiped");

        reg_write(4'h4, 32'h0000_0005);
        fire(9'h002, D_SYS,  "R5 pin code 01");
        fire(9'h004, D_FULL, "R5 brownout code 01");
        reg_write(4'h4, 32'h0000_0003);
        fire(9'h002, D_FULL, "R5 pin code 11");
        reg_read(4'h4, 32'h0, "R9 behaviour wiped by pin");

        // unions
        fire(9'h102, D_SYS,  "R7 pin with core only");
        fire(9'h101, D_FULL, "R7 power-on dominates");
        reg_read(4'h0, 32'h101, "R9 cause keeps simultaneous");
        reg_read(4'h8, 32'h0, "R10 unmapped address");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule